// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block follows the sampled clock and data lines of an I2C slave and decides, after every Start or repeated Start, whether the address that follows selects this device. The address can be a 7-bit address, or a 10-bit address sent as a header byte and then a low byte. In 7-bit mode a second 7-bit address can also be enabled. When the address matches, the block pulls the data line low for the acknowledge bit. It then raises a sticky address-hit flag, with an optional interrupt request. It also reports the transfer direction and which of the two 7-bit addresses was hit.

The line inputs must already be synchronised to `clk` and free of glitches, and each SCL phase must last at least two `clk` cycles. The `ack_o` output is an open-drain pull-down request. The data phase that follows a match is left to other logic: after a match, or after an address that does not match, the block stays passive until the next Start or Stop. The host side supplies the addresses, the mode and enable bits, and the two read strobes that clear the flag.

Top module: `i2c_addr_recognizer`

## Requirements
- R1: After reset, `ack_o`, `addr_flag_o`, `irq_o`, `dual_hit_o` and `tx_mode_o` are all 0.
- R2: In 7-bit mode (`mode10_i`=0), a first byte whose bits 7:1 equal `own_addr_i[6:0]` is a match. The block pulls SDA low for the whole ninth clock, and `addr_flag_o` rises at the SCL fall that ends that clock. `tx_mode_o` then equals bit 0 of the byte, where 1 means the slave transmits.
- R3: An address byte that does not match is never acknowledged and does not set the flag. Every later byte is ignored until the next Start, even a byte that would otherwise match.
- R4: With `ack_en_i`=0, a match drives no acknowledge, but `addr_flag_o` is still set.
- R5: With `dual_en_i`=1 in 7-bit mode, bits 7:1 equal to `own_addr2_i` also match, and `dual_hit_o` is then 1. A match on the primary address gives `dual_hit_o`=0. With `dual_en_i`=0 the second address does not match.
- R6: In 10-bit mode, a header `11110 a9 a8 0`, where a9 a8 are `own_addr_i[9:8]`, is acknowledged without setting the flag. A following byte equal to `own_addr_i[7:0]` is then acknowledged, sets the flag, and gives `tx_mode_o`=0.
- R7: In 10-bit mode, after a full two-byte match, a repeated Start followed by the header `11110 a9 a8 1` is acknowledged, sets the flag, and gives `tx_mode_o`=1.
- R8: A Stop discards the 10-bit match state, so a later header with bit 0 = 1 is not acknowledged.
- R9: `addr_flag_o` clears only when a one-cycle `sr1_rd_i` strobe, seen while the flag is set, is followed later by a `sr2_rd_i` strobe. Either strobe alone leaves the flag set.
- R10: `irq_o` is 1 exactly when `addr_flag_o` and `evt_irq_en_i` are both 1.
- R11: In 10-bit mode, a low byte that does not match is not acknowledged and discards the 10-bit match state. A header with a wrong a9 a8 is not acknowledged either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled, filtered SCL |
| sda_i | input | 1 | Sampled, filtered SDA (wired bus level) |
| mode10_i | input | 1 | 1 selects 10-bit addressing |
| dual_en_i | input | 1 | Enables the second 7-bit address |
| ack_en_i | input | 1 | Enables driving the acknowledge bit |
| evt_irq_en_i | input | 1 | Enables the interrupt request |
| own_addr_i | input | 10 | Primary address (bits 6:0 used in 7-bit mode) |
| own_addr2_i | input | 7 | Second 7-bit address |
| sr1_rd_i | input | 1 | First strobe of the flag-clear sequence |
| sr2_rd_i | input | 1 | Second strobe of the flag-clear sequence |
| ack_o | output | 1 | 1 = pull SDA low |
| addr_flag_o | output | 1 | Sticky address-hit flag |
| irq_o | output | 1 | Interrupt request |
| dual_hit_o | output | 1 | 1 = the second 7-bit address was hit |
| tx_mode_o | output | 1 | 1 = slave transmits, 0 = slave receives |

## Verification
The bench builds the block with its default widths: a 10-bit primary address, a 7-bit second address and 8-bit bytes. With these widths, all 256 first-byte values can be swept in 7-bit mode twice, once with the second address disabled and once with it enabled. Each sweep compares acknowledge, flag, direction and hit indicator against arithmetic on the byte. Directed 10-bit transfers then cover the header turnaround, a Stop between transfers, a wrong low byte, a wrong header, and the flag-clear ordering.

// File: rtl/i2c_ar_pkg.sv
package i2c_ar_pkg;
    localparam int ADDR_W  = 10;
    localparam int SHORT_W = 7;
    localparam int BYTE_W  = 8;
    localparam logic [4:0] HDR_TAG = 5'b11110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_MATCHED,
        ST_IGNORE
    } state_e;

    typedef enum logic [1:0] {
        RES_MISS,
        RES_HDR,
        RES_FULL
    } res_e;
endpackage

// File: rtl/i2c_ar_busmon.sv
module i2c_ar_busmon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    typedef struct packed {
        logic scl;
        logic sda;
    } line_t;

    line_t d, q;

    always_comb begin
        d.scl = scl_i;
        d.sda = sda_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{scl: 1'b1, sda: 1'b1};
        else        q <= d;
    end

    assign scl_rise_o = scl_i && !q.scl;
    assign scl_fall_o = !scl_i && q.scl;
    assign start_o    = scl_i && q.scl && q.sda && !sda_i;
    assign stop_o     = scl_i && q.scl && !q.sda && sda_i;
endmodule

// File: rtl/i2c_ar_shift.sv
module i2c_ar_shift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              shift_i,
    input  logic              bit_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic              full_o
);
    localparam int CNT_W = $clog2(BYTE_W + 1);

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic [CNT_W-1:0]  cnt;
    } shf_t;

    shf_t d, q;

    always_comb begin
        d = q;
        if (clr_i) begin
            d.data = '0;
            d.cnt  = '0;
        end else if (shift_i && !full_o) begin
            d.data = {q.data[BYTE_W-2:0], bit_i};
            d.cnt  = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign byte_o = q.data;
    assign full_o = (q.cnt == CNT_W'(BYTE_W));

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNT_W'(BYTE_W)); // R2
endmodule

// File: rtl/i2c_ar_match.sv
module i2c_ar_match
    import i2c_ar_pkg::*;
(
    input  logic [BYTE_W-1:0]  byte_i,
    input  logic               second_i,
    input  logic               mode10_i,
    input  logic               dual_en_i,
    input  logic               hdr_ok_i,
    input  logic [ADDR_W-1:0]  own_i,
    input  logic [SHORT_W-1:0] own2_i,
    output res_e               res_o,
    output logic               tx_o,
    output logic               dual_o
);
    logic hdr_hit, hit1, hit2;

    assign hdr_hit = (byte_i[7:3] == HDR_TAG) && (byte_i[2:1] == own_i[9:8]);
    assign hit1    = (byte_i[7:1] == own_i[SHORT_W-1:0]);
    assign hit2    = dual_en_i && (byte_i[7:1] == own2_i);

    always_comb begin
        res_o  = RES_MISS;
        tx_o   = 1'b0;
        dual_o = 1'b0;
        if (second_i) begin
            if (byte_i == own_i[BYTE_W-1:0]) res_o = RES_FULL;
        end else if (mode10_i) begin
            if (hdr_hit && !byte_i[0]) begin
                res_o = RES_HDR;
            end else if (hdr_hit && hdr_ok_i) begin
                res_o = RES_FULL;
                tx_o  = 1'b1;
            end
        end else if (hit1 || hit2) begin
            res_o  = RES_FULL;
            tx_o   = byte_i[0];
            dual_o = !hit1 && hit2;
        end
    end
endmodule

// File: rtl/i2c_addr_recognizer.sv
module i2c_addr_recognizer
    import i2c_ar_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic               mode10_i,
    input  logic               dual_en_i,
    input  logic               ack_en_i,
    input  logic               evt_irq_en_i,
    input  logic [ADDR_W-1:0]  own_addr_i,
    input  logic [SHORT_W-1:0] own_addr2_i,
    input  logic               sr1_rd_i,
    input  logic               sr2_rd_i,
    output logic               ack_o,
    output logic               addr_flag_o,
    output logic               irq_o,
    output logic               dual_hit_o,
    output logic               tx_mode_o
);
    typedef struct packed {
        state_e state;
        logic   second;
        res_e   pend;
        logic   pend_tx;
        logic   pend_dual;
        logic   hdr_ok;
        logic   ack;
        logic   flag;
        logic   armed;
        logic   tx;
        logic   dual;
    } ctl_t;

    ctl_t d, q;

    logic scl_rise_w, scl_fall_w, start_w, stop_w;
    logic shift_clr_w, shift_en_w, byte_full_w;
    logic [BYTE_W-1:0] byte_w;
    res_e res_w;
    logic res_tx_w, res_dual_w;

    i2c_ar_busmon u_busmon (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise_w),
        .scl_fall_o (scl_fall_w),
        .start_o    (start_w),
        .stop_o     (stop_w)
    );

    assign shift_en_w = scl_rise_w && (q.state == ST_ADDR);

    i2c_ar_shift #(.BYTE_W(BYTE_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (shift_clr_w),
        .shift_i (shift_en_w),
        .bit_i   (sda_i),
        .byte_o  (byte_w),
        .full_o  (byte_full_w)
    );

    i2c_ar_match u_match (
        .byte_i    (byte_w),
        .second_i  (q.second),
        .mode10_i  (mode10_i),
        .dual_en_i (dual_en_i),
        .hdr_ok_i  (q.hdr_ok),
        .own_i     (own_addr_i),
        .own2_i    (own_addr2_i),
        .res_o     (res_w),
        .tx_o      (res_tx_w),
        .dual_o    (res_dual_w)
    );

    always_comb begin
        d = q;
        shift_clr_w = 1'b0;

        // host clear sequence: first strobe arms, second strobe clears
        if (sr1_rd_i && q.flag) d.armed = 1'b1;
        if (sr2_rd_i && q.armed) begin
            d.flag  = 1'b0;
            d.armed = 1'b0;
        end

        if (stop_w) begin
            d.state  = ST_IDLE;
            d.ack    = 1'b0;
            d.hdr_ok = 1'b0;
        end else if (start_w) begin
            d.state     = ST_ADDR;
            d.second    = 1'b0;
            d.ack       = 1'b0;
            shift_clr_w = 1'b1;
        end else begin
            unique case (q.state)
                ST_ADDR: begin
                    if (scl_fall_w && byte_full_w) begin
                        if (res_w == RES_MISS) begin
                            d.state  = ST_IGNORE;
                            d.hdr_ok = 1'b0;
                        end else begin
                            d.state     = ST_ACK;
                            d.ack       = ack_en_i;
                            d.pend      = res_w;
                            d.pend_tx   = res_tx_w;
                            d.pend_dual = res_dual_w;
                            if (res_w == RES_HDR) d.hdr_ok = 1'b0;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall_w) begin
                        d.ack       = 1'b0;
                        shift_clr_w = 1'b1;
                        if (q.pend == RES_HDR) begin
                            d.state  = ST_ADDR;
                            d.second = 1'b1;
                        end else begin
                            d.state = ST_MATCHED;
                            d.flag  = 1'b1;
                            d.armed = 1'b0;
                            d.tx    = q.pend_tx;
                            d.dual  = q.pend_dual;
                            if (q.second) d.hdr_ok = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, pend: RES_MISS, default: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign ack_o       = q.ack;
    assign addr_flag_o = q.flag;
    assign irq_o       = q.flag && evt_irq_en_i;
    assign dual_hit_o  = q.dual;
    assign tx_mode_o   = q.tx;

    AST_ACK_EDGE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ack_o) |-> $past(scl_fall_w || start_w || stop_w)); // R2
    AST_ACK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_o) |-> $past(ack_en_i)); // R4
    AST_FLAG_SET_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_flag_o) |-> $past(scl_fall_w)); // R2
    AST_FLAG_CLR_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(addr_flag_o) |-> $past(sr2_rd_i)); // R9
    AST_NO_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_IGNORE) |-> !ack_o); // R3
    AST_TX10_NEEDS_HDR: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tx_mode_o) && mode10_i) |-> $past(q.hdr_ok)); // R7
endmodule

// File: tb/i2c_addr_recognizer_tb.sv
`timescale 1ns/1ps
module i2c_addr_recognizer_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tb_scl = 1'b1, tb_sda = 1'b1;
    logic mode10 = 1'b0, dual_en = 1'b0, ack_en = 1'b1, irq_en = 1'b0;
    logic [9:0] own = 10'h02A;
    logic [6:0] own2 = 7'h55;
    logic sr1 = 1'b0, sr2 = 1'b0;
    logic ack, flag, irq, dual, tx;
    logic sda_line;
    int checks = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    assign sda_line = tb_sda & ~ack;

    i2c_addr_recognizer u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(tb_scl), .sda_i(sda_line),
        .mode10_i(mode10), .dual_en_i(dual_en), .ack_en_i(ack_en),
        .evt_irq_en_i(irq_en), .own_addr_i(own), .own_addr2_i(own2),
        .sr1_rd_i(sr1), .sr2_rd_i(sr2), .ack_o(ack), .addr_flag_o(flag),
        .irq_o(irq), .dual_hit_o(dual), .tx_mode_o(tx)
    );

    task automatic chk(input logic ok, input string req, input int got, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s got=%0d exp=%0d", req, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        tb_sda = 1'b1; tick(2);
        tb_scl = 1'b1; tick(3);
        tb_sda = 1'b0; tick(3);
        tb_scl = 1'b0; tick(2);
    endtask

    task automatic bus_stop();
        tb_sda = 1'b0; tick(2);
        tb_scl = 1'b1; tick(3);
        tb_sda = 1'b1; tick(3);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            tb_sda = b[i]; tick(2);
            tb_scl = 1'b1; tick(3);
            tb_scl = 1'b0; tick(1);
        end
        tb_sda = 1'b1; tick(2);
        tb_scl = 1'b1; tick(1);
        acked = (sda_line == 1'b0);
        tick(2);
        tb_scl = 1'b0; tick(3);
    endtask

    task automatic clear_flag();
        sr1 = 1'b1; tick(1);
        sr1 = 1'b0; sr2 = 1'b1; tick(1);
        sr2 = 1'b0; tick(1);
    endtask

    task automatic sweep7(input logic den);
        logic a;
        dual_en = den;
        for (int b = 0; b < 256; b++) begin
            logic hit1, hit2, exp;
            hit1 = ((b >> 1) == int'(own[6:0]));
            hit2 = den && ((b >> 1) == int'(own2));
            exp  = hit1 || hit2;
            bus_start();
            send_byte(8'(b), a);
            chk(a == exp, den ? "R5 ack" : "R2 ack", a, exp);
            chk(flag == exp, den ? "R5 flag" : "R3 flag", flag, exp);
            if (exp) begin
                chk(tx == b[0], "R2 dir", tx, b & 1);
                chk(dual == (!hit1 && hit2), "R5 dual", dual, !hit1 && hit2);
            end
            bus_stop();
            clear_flag();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog got=0 exp=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic a;
        tick(3);
        // R1 reset state
        chk({ack, flag, irq, dual, tx} == 5'b0, "R1", {ack, flag, irq, dual, tx}, 0);
        rst_n = 1'b1; tick(3);

        sweep7(1'b0);
        sweep7(1'b1);
        dual_en = 1'b0;

        // R3: miss then a matching byte in the same transfer
        bus_start();
        send_byte(8'h20, a); chk(a == 0, "R3 miss ack", a, 0);
        send_byte(8'h54, a); chk(a == 0, "R3 later byte ignored", a, 0);
        chk(flag == 0, "R3 flag", flag, 0);
        bus_stop();

        // R4: ack disabled, flag still set
        ack_en = 1'b0;
        bus_start();
        send_byte(8'h54, a); chk(a == 0, "R4 no ack", a, 0);
        chk(flag == 1, "R4 flag", flag, 1);
        bus_stop();
        ack_en = 1'b1;

        // R10 and R9
        irq_en = 1'b1; tick(1);
        chk(irq == 1, "R10 irq on", irq, 1);
        irq_en = 1'b0; tick(1);
        chk(irq == 0, "R10 irq masked", irq, 0);
        sr2 = 1'b1; tick(1); sr2 = 1'b0; tick(1);
        chk(flag == 1, "R9 sr2 alone", flag, 1);
        sr1 = 1'b1; tick(1); sr1 = 1'b0; tick(2);
        chk(flag == 1, "R9 sr1 alone", flag, 1);
        sr2 = 1'b1; tick(1); sr2 = 1'b0; tick(1);
        chk(flag == 0, "R9 ordered clear", flag, 0);
        irq_en = 1'b1; tick(1);
        chk(irq == 0, "R10 irq no flag", irq, 0);
        irq_en = 1'b0;

        // 10-bit: own = 0x2B5 -> header 0xF4 / 0xF5, low byte 0xB5
        mode10 = 1'b1; own = 10'h2B5;
        bus_start();
        send_byte(8'hF4, a); chk(a == 1, "R6 header ack", a, 1);
        chk(flag == 0, "R6 header no flag", flag, 0);
        send_byte(8'hB5, a); chk(a == 1, "R6 low ack", a, 1);
        chk(flag == 1, "R6 flag", flag, 1);
        chk(tx == 0, "R6 rx dir", tx, 0);
        clear_flag();
        bus_start();
        send_byte(8'hF5, a); chk(a == 1, "R7 turnaround ack", a, 1);
        chk(flag == 1, "R7 flag", flag, 1);
        chk(tx == 1, "R7 tx dir", tx, 1);
        bus_stop();
        clear_flag();

        bus_start();
        send_byte(8'hF5, a); chk(a == 0, "R8 after stop", a, 0);
        chk(flag == 0, "R8 flag", flag, 0);
        bus_stop();

        bus_start();
        send_byte(8'hF4, a); chk(a == 1, "R11 header ack", a, 1);
        send_byte(8'hB4, a); chk(a == 0, "R11 wrong low", a, 0);
        chk(flag == 0, "R11 flag", flag, 0);
        bus_start();
        send_byte(8'hF5, a); chk(a == 0, "R11 state dropped", a, 0);
        bus_stop();

        bus_start();
        send_byte(8'hF2, a); chk(a == 0, "R11 wrong header bits", a, 0);
        bus_stop();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule